// File: doc/BRIEF.md
# Chained-Buffer DMA Channel

This block is one DMA channel that moves 32-bit words between a device port and memory. It works through a live window, a current address and an end address, and holds a queued follow-on window (a begin and an end address). When the live window runs out the channel can switch to the queued one on the very next word, so a stream flows across two buffers with no idle cycle.

Software drives the channel through a small register file. One word acts as the control/status register. Writes to it carry one-shot commands in bits 16 to 21, and reads return the live flags in bits 24 to 28. The channel also keeps a snapshot of all four pointers, and one command reloads the live pointers from that snapshot to restart a transfer. Completion and bus faults raise a level interrupt.

Top module: `dma_chain_ctrl`

## Requirements
- R1: After reset every pointer, every snapshot register and every flag reads zero, irq is low and mem_req is low.
- R2: Writes to the pointer registers (index 1 current, 2 end, 3 queued begin, 4 queued end) store the value with its low four bits forced to zero. They read back at the same index.
- R3: A read of index 0 returns enable at bit 24, single-update at bit 25, complete at bit 27, bus fault at bit 28 and the direction at bit 18. All other bits read zero.
- R4: In a write to index 0, bit 16 sets enable, bit 17 sets single-update and bit 19 clears complete. A zero in any of these bits changes nothing. Bit 18 is stored as the direction on every such write.
- R5: A write to index 0 with bit 20 set clears enable, single-update, complete and bus fault. This overrides any set bits in the same write, and the direction still takes bit 18.
- R6: While enable is set, dev_valid is high and the current address differs from the end address, mem_req is high and mem_addr equals the current address. Each cycle with mem_ack adds 4 to the current address and raises dev_ready.
- R7: With direction 1 (device to memory), mem_we is high and mem_wdata equals dev_wdata. With direction 0, mem_we is low and dev_rdata equals mem_rdata.
- R8: When a word brings the current address to the end address and single-update is clear, the queued begin and end become the current and end addresses. Complete sets, and enable stays set.
- R9: When that happens with single-update set, the current address equals the end address, enable clears, complete sets and mem_req stays low.
- R10: mem_err on a request sets bus fault, clears enable and leaves the pointers unchanged. Set-enable and clear-complete have no effect on bus fault or enable while bus fault is set. Only bit 20 clears it.
- R11: irq is high exactly while complete or bus fault is set.
- R12: The snapshot (index 5 current, 6 end, 7 queued begin, 8 queued end) takes the four pointers on a write to index 9. That write loads the current address, aligned as in R2, and clears complete. The snapshot also takes the post-switch pointers on every buffer switch.
- R13: A write to index 0 with bit 21 set reloads all four live pointers from the snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Register read data for reg_addr |
| dev_valid | input | 1 | Device offers a word |
| dev_ready | output | 1 | Word accepted this cycle |
| dev_wdata | input | DW | Word from the device |
| dev_rdata | output | DW | Word to the device |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (device to memory) |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |
| mem_ack | input | 1 | Memory completes the access |
| mem_err | input | 1 | Memory reports a bus fault |
| irq | output | 1 | Completion or fault interrupt |

## Verification
A bad current address shows on mem_addr during the very next request. It shows in a read of index 1 one cycle after the edge that stored it. A missed or wrong buffer switch shows at the first word past the end address: the address either falls outside both windows or mem_req stays high when it should be low. A flag held wrongly shows on irq and in the index 0 status bits in the cycle after the event. A fault that does not freeze the channel shows as a further request on the following cycle.

// File: rtl/dma_chain_ctrl.sv
module dma_chain_ctrl #(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int ALIGN_LG = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [3:0]    reg_addr,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  input  logic          dev_valid,
  output logic          dev_ready,
  input  logic [DW-1:0] dev_wdata,
  output logic [DW-1:0] dev_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack,
  input  logic          mem_err,
  output logic          irq
);

  localparam logic [AW-1:0] STEP  = AW'(DW / 8);
  localparam logic [AW-1:0] AMASK = ~((AW'(1) << ALIGN_LG) - AW'(1));

  localparam logic [3:0] IX_CSR  = 4'd0;
  localparam logic [3:0] IX_CUR  = 4'd1;
  localparam logic [3:0] IX_END  = 4'd2;
  localparam logic [3:0] IX_QBEG = 4'd3;
  localparam logic [3:0] IX_QEND = 4'd4;
  localparam logic [3:0] IX_SCUR = 4'd5;
  localparam logic [3:0] IX_SEND = 4'd6;
  localparam logic [3:0] IX_SQB  = 4'd7;
  localparam logic [3:0] IX_SQE  = 4'd8;
  localparam logic [3:0] IX_LOAD = 4'd9;

  localparam int B_SETEN  = 16;
  localparam int B_SETSUP = 17;
  localparam int B_DIR    = 18;
  localparam int B_CLRCMP = 19;
  localparam int B_RST    = 20;
  localparam int B_RELOAD = 21;
  localparam int S_EN     = 24;
  localparam int S_SUP    = 25;
  localparam int S_CMP    = 27;
  localparam int S_FLT    = 28;

  logic [AW-1:0] cur_q, end_q, qbeg_q, qend_q;
  logic [AW-1:0] scur_q, send_q, sqb_q, sqe_q;
  logic          en_q, sup_q, cmp_q, flt_q, dir_q;

  logic          csr_wr, load_wr, go, last, swap, halt, fault;
  logic [AW-1:0] cur_inc, wr_al;

  assign csr_wr  = reg_we && (reg_addr == IX_CSR);
  assign load_wr = reg_we && (reg_addr == IX_LOAD);
  assign wr_al   = reg_wdata & AMASK;
  assign cur_inc = cur_q + STEP;

  assign mem_req   = en_q && dev_valid && (cur_q != end_q);
  assign go        = mem_req && mem_ack && !mem_err;
  assign fault     = mem_req && mem_err;
  assign last      = go && (cur_inc == end_q);
  assign swap      = last && !sup_q;
  assign halt      = last && sup_q;

  assign mem_addr  = cur_q;
  assign mem_we    = dir_q;
  assign mem_wdata = dev_wdata;
  assign dev_rdata = mem_rdata;
  assign dev_ready = go;
  assign irq       = cmp_q | flt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      end_q  <= '0;
      qbeg_q <= '0;
      qend_q <= '0;
    end else begin
      if (go) cur_q <= swap ? qbeg_q : cur_inc;
      if (swap) end_q <= qend_q;
      if (csr_wr && reg_wdata[B_RELOAD]) begin
        cur_q  <= scur_q;
        end_q  <= send_q;
        qbeg_q <= sqb_q;
        qend_q <= sqe_q;
      end
      if (reg_we) begin
        case (reg_addr)
          IX_CUR, IX_LOAD: cur_q  <= wr_al;
          IX_END:          end_q  <= wr_al;
          IX_QBEG:         qbeg_q <= wr_al;
          IX_QEND:         qend_q <= wr_al;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scur_q <= '0;
      send_q <= '0;
      sqb_q  <= '0;
      sqe_q  <= '0;
    end else if (load_wr) begin
      scur_q <= wr_al;
      send_q <= end_q;
      sqb_q  <= qbeg_q;
      sqe_q  <= qend_q;
    end else if (swap) begin
      scur_q <= qbeg_q;
      send_q <= qend_q;
      sqb_q  <= qbeg_q;
      sqe_q  <= qend_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sup_q <= 1'b0;
      cmp_q <= 1'b0;
      flt_q <= 1'b0;
      dir_q <= 1'b0;
    end else begin
      if (fault) begin
        flt_q <= 1'b1;
        en_q  <= 1'b0;
      end
      if (halt) en_q <= 1'b0;
      if (csr_wr) begin
        dir_q <= reg_wdata[B_DIR];
        if (reg_wdata[B_SETEN] && !flt_q && !fault) en_q <= 1'b1;
        if (reg_wdata[B_SETSUP]) sup_q <= 1'b1;
        if (reg_wdata[B_CLRCMP]) cmp_q <= 1'b0;
      end
      if (load_wr) cmp_q <= 1'b0;
      if (last) cmp_q <= 1'b1;
      if (csr_wr && reg_wdata[B_RST]) begin
        en_q  <= 1'b0;
        sup_q <= 1'b0;
        cmp_q <= 1'b0;
        flt_q <= 1'b0;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      IX_CSR: begin
        reg_rdata[S_EN]  = en_q;
        reg_rdata[S_SUP] = sup_q;
        reg_rdata[S_CMP] = cmp_q;
        reg_rdata[S_FLT] = flt_q;
        reg_rdata[B_DIR] = dir_q;
      end
      IX_CUR:  reg_rdata = cur_q;
      IX_END:  reg_rdata = end_q;
      IX_QBEG: reg_rdata = qbeg_q;
      IX_QEND: reg_rdata = qend_q;
      IX_SCUR: reg_rdata = scur_q;
      IX_SEND: reg_rdata = send_q;
      IX_SQB:  reg_rdata = sqb_q;
      IX_SQE:  reg_rdata = sqe_q;
      default: reg_rdata = '0;
    endcase
  end

  AST_END_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    end_q[ALIGN_LG-1:0] == '0); // R2
  AST_RESET_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    csr_wr && reg_wdata[B_RST] |=> !en_q && !sup_q && !cmp_q && !flt_q); // R5
  AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    go && !last && !reg_we |=> cur_q == $past(cur_q) + STEP); // R6
  AST_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    swap && !reg_we |=> cur_q == $past(qbeg_q) && end_q == $past(qend_q) && cmp_q && en_q); // R8
  AST_SINGLE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    halt && !reg_we |=> !en_q && cmp_q && !mem_req); // R9
  AST_FAULT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    fault && !csr_wr |=> flt_q && !en_q && !mem_req); // R10
  AST_FAULT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    flt_q && !reg_we |=> $stable(cur_q) && $stable(end_q)); // R10
  AST_IRQ_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (fault || last) && !reg_we |=> irq); // R11

endmodule

// File: tb/dma_chain_ctrl_tb_top.sv
`timescale 1ns/1ps
module dma_chain_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dev_valid = 1'b0;
  logic        dev_ready;
  logic [31:0] dev_wdata = '0;
  logic [31:0] dev_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_ack, mem_err;
  logic        irq;
  logic        err_en = 1'b0;
  int          n_chk = 0;
  int          n_bad = 0;

  always #4 clk = ~clk;

  assign mem_ack   = mem_req & ~err_en;
  assign mem_err   = mem_req & err_en;
  assign mem_rdata = {16'hCAFE, mem_addr[15:0]};

  dma_chain_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dev_valid(dev_valid), .dev_ready(dev_ready), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err), .irq(irq)
  );

  // {index, write data, expected read-back}
  localparam logic [67:0] VEC [8] = '{
    {4'd1, 32'h0000_107F, 32'h0000_1070},  // R2
    {4'd2, 32'h0000_20FF, 32'h0000_20F0},  // R2
    {4'd3, 32'hFFFF_FFFF, 32'hFFFF_FFF0},  // R2
    {4'd4, 32'h0000_0008, 32'h0000_0000},  // R2
    {4'd0, 32'h0003_0000, 32'h0300_0000},  // R3 R4
    {4'd0, 32'h0004_0000, 32'h0304_0000},  // R4 dir only
    {4'd0, 32'h0017_0000, 32'h0004_0000},  // R5 wins over sets
    {4'd0, 32'h0000_0000, 32'h0000_0000}   // R4 zeros
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rdchk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    check(tag, reg_rdata, exp);
  endtask

  task automatic words(input int n);
    @(negedge clk);
    dev_valid = 1'b1;
    repeat (n) @(negedge clk);
    dev_valid = 1'b0;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 9; i++) rdchk("R1 reg", 4'(i), 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 req", {31'b0, mem_req}, 32'h0);

    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][67:64], VEC[i][63:32]);
      rdchk("R2/R3/R4/R5 vector", VEC[i][67:64], VEC[i][31:0]);
    end

    wr(4'd1, 32'h100); wr(4'd2, 32'h110); wr(4'd3, 32'h200); wr(4'd4, 32'h210);
    wr(4'd0, 32'h0005_0000);
    @(negedge clk);
    dev_valid = 1'b1; dev_wdata = 32'hA5A5_0001;
    #1;
    check("R6 req", {31'b0, mem_req}, 32'h1);
    check("R6 addr", mem_addr, 32'h100);
    check("R6 ready", {31'b0, dev_ready}, 32'h1);
    check("R7 we", {31'b0, mem_we}, 32'h1);
    check("R7 wdata", mem_wdata, 32'hA5A5_0001);
    repeat (4) @(negedge clk);
    dev_valid = 1'b0;
    rdchk("R8 cur", 4'd1, 32'h200);
    rdchk("R8 end", 4'd2, 32'h210);
    rdchk("R8 csr", 4'd0, 32'h0904_0000);
    check("R11 irq set", {31'b0, irq}, 32'h1);
    rdchk("R12 snap cur", 4'd5, 32'h200);
    rdchk("R12 snap end", 4'd6, 32'h210);

    wr(4'd0, 32'h000C_0000);
    rdchk("R4 clear complete", 4'd0, 32'h0104_0000);
    check("R11 irq clear", {31'b0, irq}, 32'h0);

    wr(4'd0, 32'h0006_0000);
    rdchk("R4 set single", 4'd0, 32'h0304_0000);
    words(4);
    rdchk("R9 csr", 4'd0, 32'h0A04_0000);
    rdchk("R9 cur", 4'd1, 32'h210);
    @(negedge clk);
    dev_valid = 1'b1;
    #1;
    check("R9 no req", {31'b0, mem_req}, 32'h0);
    dev_valid = 1'b0;

    wr(4'd0, 32'h0010_0000);
    rdchk("R5 reset cmd", 4'd0, 32'h0);
    wr(4'd9, 32'h305);
    rdchk("R12 load cur", 4'd1, 32'h300);
    rdchk("R12 snap load", 4'd5, 32'h300);
    rdchk("R12 snap end", 4'd6, 32'h210);
    rdchk("R12 snap qbeg", 4'd7, 32'h200);
    wr(4'd2, 32'h320);
    wr(4'd0, 32'h0001_0000);
    @(negedge clk);
    dev_valid = 1'b1;
    #1;
    check("R7 read dir we", {31'b0, mem_we}, 32'h0);
    check("R7 dev_rdata", dev_rdata, 32'hCAFE_0300);
    @(negedge clk);
    @(negedge clk);
    dev_valid = 1'b0;
    rdchk("R6 two words", 4'd1, 32'h308);

    err_en = 1'b1;
    words(1);
    rdchk("R10 fault flag", 4'd0, 32'h1000_0000);
    rdchk("R10 frozen", 4'd1, 32'h308);
    check("R11 irq fault", {31'b0, irq}, 32'h1);
    wr(4'd0, 32'h0001_0000);
    rdchk("R10 set-enable ignored", 4'd0, 32'h1000_0000);
    wr(4'd0, 32'h0008_0000);
    rdchk("R10 clear-complete ignored", 4'd0, 32'h1000_0000);
    wr(4'd0, 32'h0010_0000);
    rdchk("R10 reset clears", 4'd0, 32'h0);
    err_en = 1'b0;

    wr(4'd0, 32'h0020_0000);
    rdchk("R13 cur", 4'd1, 32'h300);
    rdchk("R13 end", 4'd2, 32'h210);
    rdchk("R13 qbeg", 4'd3, 32'h200);
    rdchk("R13 qend", 4'd4, 32'h210);

    finish_run();
  end
endmodule